// File: doc/BRIEF.md
# Converter Output Code Formatter

This block sits between an ideal 10-bit conversion core and the pins of a data converter. Each clock, the core offers an unsigned raw code, a strobe that marks the code as a real sample, and the signed level of that sample before any clamping. The formatter finds inputs above or below the coding range and saturates them. It then applies two independent inversion controls and registers the result. The first control flips the most significant bit. The second control flips the nine bits below it.

The four combinations of the controls give straight binary, two's complement, and the bit-inverted form of each. A positive overrange raises a separate flag. An underrange only saturates the word at the bottom and never raises the flag. The formatted word appears a fixed two cycles after the sample is captured. It stays on the outputs for one cycle, marked by an output strobe.

The format controls are expected to be tied low when not in use. They are captured in the same register as the sample they apply to.

Top module: `adc_code_fmt`

## Requirements
- R1: While `rst` is high at a rising edge, every pipeline stage is cleared. After that edge `out_word` is 0, `out_ovr` is 0 and `out_valid` is 0. For the next two cycles after release, `out_valid` stays 0.
- R2: Inputs sampled at rising edge e produce their result on the outputs right after edge e+2. A sample with `smp_valid` high gives `out_valid` high for exactly that one cycle. A sample with `smp_valid` low gives `out_valid`, `out_ovr` and `out_word` all 0.
- R3: With both controls low and `smp_level` in 0..1023, `out_word` equals `raw_code` (straight binary: 0x000 is the bottom of the range, 0x200 is the midpoint, 0x3FF is the top).
- R4: With `msb_flip` high, bit 9 of the word is inverted. For example, midpoint raw 0x200 becomes 0x000 (two's complement).
- R5: With `lsb_flip` high, bits 8..0 of the word are inverted. For example, raw 0x200 becomes 0x3FF.
- R6: With both controls high, raw code x gives the bitwise complement of x (inverted binary). For example, 0x000 becomes 0x3FF.
- R7: If `smp_level` > 1023, `raw_code` is ignored and `out_ovr` is 1. The word is 0x3FF after the selected inversions: 0x3FF, 0x1FF, 0x200 or 0x000. A level of exactly 1023 gives `out_ovr` 0.
- R8: If `smp_level` < 0, `raw_code` is ignored and `out_ovr` stays 0. The word is 0x000 after the selected inversions.
- R9: The format controls are taken at the same edge as the sample. Consecutive samples with different controls are each formatted by their own controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Marks the current inputs as a sample |
| raw_code | input | 10 | Unsigned code from the core |
| smp_level | input | 12 | Signed level before clamping, in code steps |
| msb_flip | input | 1 | Invert bit 9 when high |
| lsb_flip | input | 1 | Invert bits 8..0 when high |
| out_word | output | 10 | Formatted code, bit 9 most significant |
| out_ovr | output | 1 | Positive overrange flag |
| out_valid | output | 1 | Outputs carry a sample this cycle |

## Verification
A wrong pipeline depth or a dropped stage shows at the ports as a word that arrives one cycle early or late. It fails on the first sample after reset. A format control captured at a different stage from its data mixes formats between neighbouring words. It shows within two cycles whenever the controls change between back-to-back samples. A wrong range test shows on the first sample at level 1023, 1024 or -1, as a wrong flag or an unsaturated word.

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
  parameter int CODE_W = 10,
  parameter int LVL_W  = 12,
  parameter int LAT    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic [CODE_W-1:0]        raw_code,
  input  logic signed [LVL_W-1:0]  smp_level,
  input  logic                     msb_flip,
  input  logic                     lsb_flip,
  output logic [CODE_W-1:0]        out_word,
  output logic                     out_ovr,
  output logic                     out_valid
);
  localparam int STG = LAT + 1;
  localparam int TOP = (1 << CODE_W) - 1;

  logic              over, under;
  logic [CODE_W-1:0] clamped, fmt;
  logic [CODE_W-1:0] pw [STG];
  logic              po [STG];
  logic              pv [STG];

  assign over    = smp_level > TOP;
  assign under   = smp_level < 0;
  assign clamped = over ? '1 : (under ? '0 : raw_code);
  assign fmt     = {clamped[CODE_W-1] ^ msb_flip,
                    clamped[CODE_W-2:0] ^ {(CODE_W-1){lsb_flip}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STG; i++) begin
        pw[i] <= '0;
        po[i] <= 1'b0;
        pv[i] <= 1'b0;
      end
    end else begin
      pw[0] <= smp_valid ? fmt : '0;
      po[0] <= smp_valid & over;
      pv[0] <= smp_valid;
      for (int i = 1; i < STG; i++) begin
        pw[i] <= pw[i-1];
        po[i] <= po[i-1];
        pv[i] <= pv[i-1];
      end
    end
  end

  assign out_word  = pw[STG-1];
  assign out_ovr   = po[STG-1];
  assign out_valid = pv[STG-1];

  assert_rst_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ovr && out_word == '0));

  assert_ovr_has_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_ovr |-> out_valid);

  assert_ovr_saturated_R7: assert property (@(posedge clk) disable iff (rst)
    out_ovr |-> ($countones(out_word[CODE_W-2:0]) == 0 ||
                 $countones(out_word[CODE_W-2:0]) == CODE_W-1));

  assert_no_flag_below_R8: assert property (@(posedge clk) disable iff (rst)
    po[0] |-> ($past(smp_level) > TOP));
endmodule

// File: tb/sim_adc_code_fmt.sv
module sim_adc_code_fmt;
  localparam time TCLK = 10ns;
  localparam int  WDOG = 100000;

  logic clk = 1'b0, rst = 1'b1;
  logic valid_i = 1'b0, hi_i = 1'b0, lo_i = 1'b0;
  logic [9:0] raw_i = '0;
  logic signed [11:0] lvl_i = '0;
  logic [9:0] out_word;
  logic out_ovr, out_valid;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  bit model_on = 1'b0, done = 1'b0;

  logic [9:0] ew [1:3];
  logic       eo [1:3];
  logic       ev [1:3];

  always #(TCLK/2) clk = ~clk;

  adc_code_fmt u0 (
    .clk(clk), .rst(rst), .smp_valid(valid_i), .raw_code(raw_i),
    .smp_level(lvl_i), .msb_flip(hi_i), .lsb_flip(lo_i),
    .out_word(out_word), .out_ovr(out_ovr), .out_valid(out_valid));

  function automatic logic [10:0] predict(logic v, logic [9:0] raw,
      int lvl, logic hi, logic lo);
    int code;
    logic o;
    if (!v) return 11'd0;
    o = lvl > 1023;
    if (lvl > 1023) code = 1023;
    else if (lvl < 0) code = 0;
    else code = raw;
    if (hi) code = code ^ 512;
    if (lo) code = code ^ 511;
    return {o, 10'(code)};
  endfunction

  always @(posedge clk) begin
    logic [10:0] p;
    cycles++;
    p = predict(valid_i, raw_i, lvl_i, hi_i, lo_i);
    ew[3] = ew[2]; eo[3] = eo[2]; ev[3] = ev[2];
    ew[2] = ew[1]; eo[2] = eo[1]; ev[2] = ev[1];
    ew[1] = p[9:0]; eo[1] = p[10]; ev[1] = valid_i;
    if (rst) for (int i = 1; i <= 3; i++) begin ew[i] = '0; eo[i] = 0; ev[i] = 0; end
    if (cycles > WDOG && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
      finish_up();
    end
  end

  always @(negedge clk) if (model_on) begin
    compared++;
    if (out_word !== ew[3] || out_ovr !== eo[3] || out_valid !== ev[3]) begin
      mismatched++;
      $display("FAIL %s model: actual w=%h o=%b v=%b expected w=%h o=%b v=%b",
               cur_req, out_word, out_ovr, out_valid, ew[3], eo[3], ev[3]);
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic chk(string req, logic [9:0] w, logic o, logic v);
    compared++;
    if (out_word !== w || out_ovr !== o || out_valid !== v) begin
      mismatched++;
      $display("FAIL %s: actual w=%h o=%b v=%b expected w=%h o=%b v=%b",
               req, out_word, out_ovr, out_valid, w, o, v);
    end
  endtask

  task automatic one_shot(string req, int lvl, logic [9:0] raw, logic hi,
      logic lo, logic [9:0] w, logic o);
    cur_req = req;
    @(negedge clk);
    valid_i = 1; lvl_i = 12'(lvl); raw_i = raw; hi_i = hi; lo_i = lo;
    @(negedge clk);
    valid_i = 0; hi_i = 0; lo_i = 0; raw_i = '0; lvl_i = '0;
    @(negedge clk);
    chk({req, " early"}, 10'h000, 1'b0, 1'b0);
    @(negedge clk);
    chk(req, w, o, 1'b1);
    @(negedge clk);
    chk({req, " one-cycle"}, 10'h000, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 10'h000, 1'b0, 1'b0);
    rst = 0;
    @(negedge clk); chk("R1 after release", 10'h000, 1'b0, 1'b0);
    @(negedge clk); chk("R1 after release", 10'h000, 1'b0, 1'b0);
    model_on = 1'b1;

    one_shot("R3 binary", 341, 10'h155, 0, 0, 10'h155, 0);
    one_shot("R3 top", 1023, 10'h3FF, 0, 0, 10'h3FF, 0);
    one_shot("R4 twos mid", 512, 10'h200, 1, 0, 10'h000, 0);
    one_shot("R5 inv twos mid", 512, 10'h200, 0, 1, 10'h3FF, 0);
    one_shot("R6 inv binary", 0, 10'h000, 1, 1, 10'h3FF, 0);
    one_shot("R7 over binary", 1024, 10'h012, 0, 0, 10'h3FF, 1);
    one_shot("R7 over twos", 2000, 10'h000, 1, 0, 10'h1FF, 1);
    one_shot("R7 over inv twos", 1500, 10'h0F0, 0, 1, 10'h200, 1);
    one_shot("R7 over inv binary", 2047, 10'h3FF, 1, 1, 10'h000, 1);
    one_shot("R8 under binary", -1, 10'h3AB, 0, 0, 10'h000, 0);
    one_shot("R8 under twos", -2048, 10'h155, 1, 0, 10'h200, 0);
    one_shot("R8 under inv binary", -7, 10'h001, 1, 1, 10'h3FF, 0);

    cur_req = "R9";
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      valid_i = 1; hi_i = i[0]; lo_i = i[1];
      raw_i = 10'($urandom); lvl_i = (i % 5 == 0) ? 12'sd1100 : 12'(raw_i);
    end

    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      valid_i = $urandom_range(0, 3) != 0;
      hi_i = $urandom_range(0, 1); lo_i = $urandom_range(0, 1);
      raw_i = 10'($urandom);
      lvl_i = ($urandom_range(0, 5) == 0) ? 12'($urandom) : 12'(raw_i);
      if (i == 300) begin cur_req = "R1"; rst = 1; end
      if (i == 302) begin rst = 0; cur_req = "R2"; end
    end
    @(negedge clk); valid_i = 0;
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule